// File: doc/BRIEF.md
# Infrared Mark/Space Width Capture

This block watches the output of a demodulated infrared receiver and measures how long the line stays in each state. After a rearm it waits for the line to go low, which is the start of the first mark. From then on it times each mark and each space in units of a programmable sample tick. Each length is an 8-bit count, and the counts go into a bank of byte slots. A host reads the slots as 32-bit words over a plain register port.

A message is complete in one of two ways:
- a space lasts a full 255 ticks;
- every slot in the bank holds a value.

When either happens, the bank freezes and an interrupt status bit is set. The host reads the words, then writes the rearm command. That command zeroes the bank and returns the receiver to waiting for the next message.

The tick comes from two stages. The source clock is first divided by four. The divided clock is then divided again by a 13-bit period that software writes.

Top module: `irw_capture`

## Requirements
- R1: After reset, all 17 capture words (word addresses 0x10 to 0x20) read zero and `irq` is low. The control word (address 0x00) reads zero, the tick word (address 0x01) reads 0xC00 in bits 20:8, and the interrupt-enable word (address 0x03) reads zero.
- R2: One sample tick occurs every 4 × P source clocks, where P is the value in bits 20:8 of the tick word (P = 0 acts as 1). A stored width equals the number of ticks that fell within the interval. An interval of exactly n × 4 × P clocks is therefore stored as n.
- R3: Capture runs only while bit 0 (receiver on) and bit 13 (width timing on) of the control word are both 1. Otherwise input edges have no effect and the bank is unchanged.
- R4: After a rearm, the receiver ignores the idle-high line and starts on the first falling edge. Slot 0 holds a mark (low level). Slots then alternate between mark and space.
- R5: Slot k is read from word address 0x10 + k/4, in bits 8·(k mod 4)+7 down to 8·(k mod 4). Slot 0 is in bits 7:0 of address 0x10.
- R6: A mark longer than 255 ticks is stored as 0xFF, and capture continues with the following space.
- R7: A space that reaches 255 ticks is stored as 0xFF and ends the message. The bank then freezes and the interrupt status is set.
- R8: When the 68th slot has been written, the bank freezes and the interrupt status is set. Later intervals are discarded until the next rearm.
- R9: Writing 1 to bit 0 of address 0x02 zeroes all capture words and returns the receiver to waiting for a falling edge.
- R10: `irq` equals the interrupt status ANDed with bit 0 of address 0x03. Writing 1 to bit 0 of address 0x04 clears the status. A message end in the same cycle takes priority over the clear.
- R11: Reads have no side effects. Reading the same capture word again returns the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irIn | input | 1 | Demodulated receiver line, low = mark |
| wrEn | input | 1 | Single-cycle write strobe |
| wrAddr | input | 6 | Word address of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 6 | Word address of the read |
| rdData | output | 32 | Read data, combinational from rdAddr |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives mark/space trains whose lengths are exact multiples of the tick length. The expected byte in each slot is then known exactly, whatever the prescaler phase, and the whole bank is swept against an array built in the bench.

Each train tests a different case:
- A short mixed-width message ending on an idle space shows that the packing is correct and that the space ends the message.
- A 70-interval train with cycling widths checks the full-bank stop and that the extra intervals are dropped.
- A 300-tick mark checks saturation without an end.
- A run with width timing switched off checks that capture is gated.
- A second tick period checks that widths scale with the period field.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_CTRL   = 6'h00;
  localparam logic [ADDR_W-1:0] A_TICK   = 6'h01;
  localparam logic [ADDR_W-1:0] A_REARM  = 6'h02;
  localparam logic [ADDR_W-1:0] A_IRQEN  = 6'h03;
  localparam logic [ADDR_W-1:0] A_IRQACK = 6'h04;
  localparam logic [ADDR_W-1:0] A_CAP    = 6'h10;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} capState_t;

  typedef struct packed {
    logic start;     // first falling edge: open slot 0
    logic store;     // edge: write current width to slot
    logic storeSat;  // space hit the limit: write 0xFF to slot
    logic count;     // advance the width counter on a tick
    logic clearAll;  // rearm: zero bank and counters
  } capStrobe_t;
endpackage

// File: rtl/irw_tick.sv
module irw_tick #(
  parameter int DIV   = 4,
  parameter int PER_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DIV_W-1:0] divCnt;
  logic [PER_W-1:0] perCnt;
  logic [PER_W-1:0] lastCnt;
  logic             divEn;

  assign divEn   = (divCnt == DIV_W'(DIV - 1));
  assign lastCnt = (period == '0) ? '0 : period - 1'b1;
  assign tick    = divEn && (perCnt >= lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      perCnt <= '0;
    end else begin
      divCnt <= divEn ? '0 : divCnt + 1'b1;
      if (divEn) perCnt <= tick ? '0 : perCnt + 1'b1;
    end
  end
endmodule

// File: rtl/irw_datapath.sv
module irw_datapath
  import irw_pkg::*;
#(
  parameter int WORDS = 17,
  parameter int W_BITS = 8,
  localparam int SLOTS  = WORDS * 4,
  localparam int SLOT_W = $clog2(SLOTS + 1),
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irIn,
  input  logic              tick,
  input  capStrobe_t        strb,
  input  logic [WIDX_W-1:0] rdWordIdx,
  output logic              edgeNow,
  output logic              markNow,
  output logic [W_BITS-1:0] width,
  output logic [SLOT_W-1:0] slotIdx,
  output logic [31:0]       rdWord
);
  localparam logic [W_BITS-1:0] W_MAX = '1;

  logic syncA, syncB, lastLvl;
  logic [W_BITS-1:0] bank [SLOTS];
  logic writeSlot;

  assign edgeNow   = syncB ^ lastLvl;
  assign markNow   = ~syncB;
  assign writeSlot = strb.store | strb.storeSat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b1;
      syncB   <= 1'b1;
      lastLvl <= 1'b1;
    end else begin
      syncA   <= irIn;
      syncB   <= syncA;
      lastLvl <= syncB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      width   <= '0;
      slotIdx <= '0;
    end else if (strb.clearAll) begin
      width   <= '0;
      slotIdx <= '0;
    end else if (strb.start) begin
      width   <= W_BITS'(tick);
      slotIdx <= '0;
    end else if (writeSlot) begin
      width   <= W_BITS'(tick);
      slotIdx <= slotIdx + 1'b1;
    end else if (strb.count && tick && width != W_MAX) begin
      width   <= width + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) bank[i] <= '0;
    end else if (strb.clearAll) begin
      for (int i = 0; i < SLOTS; i++) bank[i] <= '0;
    end else if (writeSlot && slotIdx < SLOT_W'(SLOTS)) begin
      bank[slotIdx] <= strb.storeSat ? W_MAX : width;
    end
  end

  always_comb begin
    rdWord = '0;
    for (int j = 0; j < 4; j++) begin
      logic [WIDX_W+1:0] idx;
      idx = {rdWordIdx, 2'(j)};
      if (idx < (WIDX_W+2)'(SLOTS)) rdWord[8*j +: 8] = 8'(bank[idx]);
    end
  end
endmodule

// File: rtl/irw_control.sv
module irw_control
  import irw_pkg::*;
#(
  parameter int SLOTS = 68,
  parameter int W_BITS = 8,
  localparam int SLOT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capEn,
  input  logic              rearm,
  input  logic              edgeNow,
  input  logic              markNow,
  input  logic              tick,
  input  logic [W_BITS-1:0] width,
  input  logic [SLOT_W-1:0] slotIdx,
  output capStrobe_t        strb,
  output logic              doneEvt,
  output capState_t         capState
);
  localparam logic [W_BITS-1:0] W_NEAR = W_BITS'((1 << W_BITS) - 2);

  capState_t nxtState;

  always_comb begin
    strb     = '0;
    doneEvt  = 1'b0;
    nxtState = capState;
    if (rearm) begin
      strb.clearAll = 1'b1;
      nxtState      = ST_IDLE;
    end else begin
      unique case (capState)
        ST_IDLE: if (capEn && edgeNow && markNow) begin
          strb.start = 1'b1;
          nxtState   = ST_RUN;
        end
        ST_RUN: if (capEn) begin
          if (edgeNow) begin
            strb.store = 1'b1;
            if (slotIdx == SLOT_W'(SLOTS - 1)) begin
              doneEvt  = 1'b1;
              nxtState = ST_DONE;
            end
          end else begin
            strb.count = 1'b1;
            if (tick && slotIdx[0] && width == W_NEAR) begin
              strb.storeSat = 1'b1;
              doneEvt       = 1'b1;
              nxtState      = ST_DONE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capState <= ST_IDLE;
    else       capState <= nxtState;
  end
endmodule

// File: rtl/irw_capture.sv
module irw_capture
  import irw_pkg::*;
#(
  parameter int WORDS    = 17,
  parameter int CLK_DIV  = 4,
  parameter int PER_W    = 13,
  parameter int PER_INIT = 'hC00,
  localparam int SLOTS  = WORDS * 4,
  localparam int SLOT_W = $clog2(SLOTS + 1),
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              irq
);
  logic             rxOn, widthOn, intEnReg, intStatus;
  logic [PER_W-1:0] tickPeriod;
  logic             capEn, rearm, ack, tick, doneEvt;
  logic             edgeNow, markNow;
  logic [7:0]       width;
  logic [SLOT_W-1:0] slotIdx;
  capStrobe_t       strb;
  capState_t        capState;
  logic [ADDR_W-1:0] capOff;
  logic             inCap;
  logic [31:0]      capWord;

  assign capEn = rxOn & widthOn;
  assign rearm = wrEn && wrAddr == A_REARM && wrData[0];
  assign ack   = wrEn && wrAddr == A_IRQACK && wrData[0];
  assign irq   = intStatus & intEnReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxOn       <= 1'b0;
      widthOn    <= 1'b0;
      intEnReg   <= 1'b0;
      tickPeriod <= PER_W'(PER_INIT);
      intStatus  <= 1'b0;
    end else begin
      if (wrEn && wrAddr == A_CTRL) begin
        rxOn    <= wrData[0];
        widthOn <= wrData[13];
      end
      if (wrEn && wrAddr == A_TICK)  tickPeriod <= wrData[8 +: PER_W];
      if (wrEn && wrAddr == A_IRQEN) intEnReg   <= wrData[0];
      if (doneEvt)  intStatus <= 1'b1;
      else if (ack) intStatus <= 1'b0;
    end
  end

  irw_tick #(.DIV(CLK_DIV), .PER_W(PER_W)) uTick (
    .clk(clk), .rstN(rstN), .period(tickPeriod), .tick(tick)
  );

  irw_control #(.SLOTS(SLOTS), .W_BITS(8)) uCtl (
    .clk(clk), .rstN(rstN), .capEn(capEn), .rearm(rearm),
    .edgeNow(edgeNow), .markNow(markNow), .tick(tick), .width(width),
    .slotIdx(slotIdx), .strb(strb), .doneEvt(doneEvt), .capState(capState)
  );

  assign capOff = rdAddr - A_CAP;
  assign inCap  = (rdAddr >= A_CAP) && (capOff < ADDR_W'(WORDS));

  irw_datapath #(.WORDS(WORDS), .W_BITS(8)) uDp (
    .clk(clk), .rstN(rstN), .irIn(irIn), .tick(tick), .strb(strb),
    .rdWordIdx(capOff[WIDX_W-1:0]), .edgeNow(edgeNow), .markNow(markNow),
    .width(width), .slotIdx(slotIdx), .rdWord(capWord)
  );

  always_comb begin
    rdData = '0;
    if (inCap) rdData = capWord;
    else begin
      unique case (rdAddr)
        A_CTRL:  begin rdData[0] = rxOn; rdData[13] = widthOn; end
        A_TICK:  rdData[8 +: PER_W] = tickPeriod;
        A_IRQEN: rdData[0] = intEnReg;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irw_capture_chk.sv
module irw_capture_chk
  import irw_pkg::*;
#(
  parameter int SLOTS = 68,
  localparam int SLOT_W = $clog2(SLOTS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              irq,
  input logic              intEnReg,
  input logic              intStatus,
  input logic              ack,
  input logic              doneEvt,
  input logic              rearm,
  input logic              capEn,
  input logic [7:0]        width,
  input logic [SLOT_W-1:0] slotIdx,
  input capState_t         capState
);
  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> intEnReg);
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !doneEvt) |=> !intStatus);
  a_r7_end_sets_status: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |=> intStatus);
  a_r9_rearm_restarts: assert property (@(posedge clk) disable iff (!rstN)
    rearm |=> (slotIdx == '0 && capState == ST_IDLE));
  a_r8_slot_bound: assert property (@(posedge clk) disable iff (!rstN)
    slotIdx <= SLOT_W'(SLOTS));
  a_r8_frozen_when_done: assert property (@(posedge clk) disable iff (!rstN)
    (capState == ST_DONE && !rearm) |=> (capState == ST_DONE && $stable(slotIdx)));
  a_r3_gated_capture: assert property (@(posedge clk) disable iff (!rstN)
    (!capEn && !rearm) |=> ($stable(width) && $stable(slotIdx)));
endmodule

bind irw_capture irw_capture_chk #(.SLOTS(SLOTS)) uChk (
  .clk(clk), .rstN(rstN), .irq(irq), .intEnReg(intEnReg),
  .intStatus(intStatus), .ack(ack), .doneEvt(doneEvt), .rearm(rearm),
  .capEn(capEn), .width(width), .slotIdx(slotIdx), .capState(capState)
);

// File: tb/tb_irw_capture.sv
module tb_irw_capture;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irIn = 1'b1;
  logic wrEn = 1'b0;
  logic [5:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [5:0] rdAddr = '0;
  logic [31:0] rdData;
  logic irq;

  int nChk = 0;
  int nFail = 0;
  int tLen = 8;
  int expv [68];
  bit finished = 0;

  always #10 clk = ~clk;

  irw_capture dut (
    .clk(clk), .rstN(rstN), .irIn(irIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic hold(input logic lvl, input int ticks);
    irIn = lvl;
    repeat (ticks * tLen) @(negedge clk);
  endtask

  task automatic clearExp();
    for (int k = 0; k < 68; k++) expv[k] = 0;
  endtask

  task automatic checkBank(input string req);
    logic [31:0] got;
    for (int w = 0; w < 17; w++) begin
      rd(6'(16 + w), got);
      chk(req, got, {8'(expv[4*w+3]), 8'(expv[4*w+2]), 8'(expv[4*w+1]), 8'(expv[4*w])});
    end
  endtask

  task automatic rearmAll();
    wr(6'h02, 32'h1);
    wr(6'h04, 32'h1);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] v, v2;
    int w1 [9] = '{3, 2, 5, 1, 4, 7, 2, 9, 1};
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    clearExp();
    checkBank("R1 bank");
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(6'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(6'h01, v); chk("R1 tick", v, 32'h000C_0000);
    rd(6'h03, v); chk("R1 irqen", v, 32'h0);

    // R11 configuration read-back
    wr(6'h00, 32'h0000_2001);
    wr(6'h01, 32'h0000_0200);
    wr(6'h03, 32'h1);
    rd(6'h00, v); chk("R11 ctrl", v, 32'h0000_2001);
    rd(6'h01, v); chk("R11 tick", v, 32'h0000_0200);
    tLen = 8;

    // R2 R4 R5 R7 message with space end
    hold(1'b1, 5);
    for (int i = 0; i < 9; i++) hold((i % 2) ? 1'b1 : 1'b0, w1[i]);
    chk("R7 irq before end", {31'b0, irq}, 32'h0);
    hold(1'b1, 260);
    clearExp();
    for (int i = 0; i < 9; i++) expv[i] = w1[i];
    expv[9] = 255;
    checkBank("R5 R2 R4 R7 packing");
    chk("R7 irq after end", {31'b0, irq}, 32'h1);
    rd(6'h10, v); rd(6'h10, v2); chk("R11 reread", v2, v);

    // R10 gating and ack
    wr(6'h03, 32'h0);
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    wr(6'h03, 32'h1);
    chk("R10 irq unmasked", {31'b0, irq}, 32'h1);
    wr(6'h04, 32'h1);
    chk("R10 irq ack", {31'b0, irq}, 32'h0);

    // R9 rearm zeroes bank
    wr(6'h02, 32'h1);
    clearExp();
    checkBank("R9 cleared");

    // R8 full bank, extras discarded
    wr(6'h04, 32'h1);
    for (int i = 0; i < 70; i++) begin
      hold((i % 2) ? 1'b1 : 1'b0, (i % 4) + 1);
      if (i == 66) chk("R8 irq before full", {31'b0, irq}, 32'h0);
    end
    hold(1'b1, 3);
    chk("R8 irq full", {31'b0, irq}, 32'h1);
    hold(1'b0, 4);
    hold(1'b1, 260);
    for (int k = 0; k < 68; k++) expv[k] = (k % 4) + 1;
    checkBank("R8 full bank");

    // R6 mark saturation
    rearmAll();
    hold(1'b0, 300);
    hold(1'b1, 3);
    hold(1'b0, 2);
    chk("R6 irq no end", {31'b0, irq}, 32'h0);
    hold(1'b1, 260);
    clearExp();
    expv[0] = 255; expv[1] = 3; expv[2] = 2; expv[3] = 255;
    checkBank("R6 saturation");

    // R3 gating: width timing off
    rearmAll();
    wr(6'h00, 32'h0000_0001);
    hold(1'b0, 3); hold(1'b1, 2); hold(1'b0, 4); hold(1'b1, 2);
    clearExp();
    checkBank("R3 disabled");
    chk("R3 irq", {31'b0, irq}, 32'h0);

    // R2 second tick period
    wr(6'h00, 32'h0000_2001);
    wr(6'h01, 32'h0000_0100);
    tLen = 4;
    hold(1'b1, 3);
    hold(1'b0, 2); hold(1'b1, 3); hold(1'b0, 6);
    hold(1'b1, 258);
    clearExp();
    expv[0] = 2; expv[1] = 3; expv[2] = 6; expv[3] = 255;
    checkBank("R2 period one");
    chk("R2 irq", {31'b0, irq}, 32'h1);

    report();
  end
endmodule